// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Vector Unit

This block keeps the exception state of a floating-point coprocessor and decides what happens at the end of each arithmetic operation. It holds an 8-bit trap-enable byte and a 32-bit status word. The status word carries a per-operation exception byte and a sticky accrued byte. When an operation begins, the per-operation byte is cleared. When the operation reports its event flags, they are merged into that byte and folded into the accrued summary.

In the cycle after the operation finishes, the unit makes one of two decisions. If any status bit is set whose enable bit is also set, it issues a one-cycle trap request with a vector number. The vector comes from the most urgent such bit. Otherwise it issues a one-cycle commit strobe, which lets the result write-back and the condition-code update go ahead. Software can load the enable byte, and it can load the exception fields of the status word. Loading the status word is the only way to clear accrued bits other than reset.

Top module: `fpx_trap_unit`

## Requirements
- R1: After reset, `status_q` and `enable_q` are zero, and `trap_req`, `commit` and `trap_vec` are low or zero.
- R2: When `en_wr` is high at a clock edge, `en_wr_data` appears on `enable_q` after that edge.
- R3: When `op_start` is high at an edge, `status_q[15:8]` is zero after that edge unless `op_done` adds flags in the same cycle. The accrued bits are left unchanged.
- R4: `status_q[15:8]` is the per-operation byte, ordered from bit 15 down to bit 8: unordered-compare, signaling NaN, operand error, overflow, underflow, divide-by-zero, inexact result, inexact decimal input. When `op_done` is high, `evt_flags` (same order) is ORed into it. When `op_start` and `op_done` are high together, the byte is cleared first and then the flags are merged.
- R5: When `op_done` is high, accrued invalid (bit 7) is set if bit 15, bit 14 or bit 13 of the merged byte is set.
- R6: When `op_done` is high, accrued underflow (bit 5) is set only if both underflow (bit 11) and inexact result (bit 9) are set in the merged byte.
- R7: When `op_done` is high, the following accrued bits are set from the merged byte:
  - accrued overflow (bit 6) from bit 12;
  - accrued divide-by-zero (bit 4) from bit 10;
  - accrued inexact (bit 3) from bit 12, bit 9 or bit 8.

  Accrued bits never clear except by reset or a status write.
- R8: One cycle after `op_done`, `trap_req` pulses if the merged byte ANDed with the enable byte (same bit order) is nonzero. `trap_vec` then gives the vector of the highest set bit of that AND. From bit 7 down to bit 0 the vectors are 48, 54, 52, 53, 51, 50, 49, 49.
- R9: One cycle after `op_done`, `commit` pulses exactly when `trap_req` does not. The two never pulse together, and neither pulses without an `op_done` in the cycle before.
- R10: A status write (`st_wr`) loads `st_wr_exc` into bits 15:8 and `st_wr_acc` into bits 7:3. Bits 31:16 and 2:0 always read zero.
- R11: When a status write and `op_done` share a cycle, the written value is the base that the clear and merge act on. When an enable write and `op_done` share a cycle, the trap decision uses the enable byte from before the write.
- R12: `trap_vec` is zero whenever `trap_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | An arithmetic operation begins; clears the per-operation byte |
| op_done | input | 1 | The operation ends; `evt_flags` are valid |
| evt_flags | input | 8 | Exception events raised by the operation |
| en_wr | input | 1 | Load the trap-enable byte |
| en_wr_data | input | 8 | New trap-enable byte |
| st_wr | input | 1 | Load the status word |
| st_wr_exc | input | 8 | New per-operation exception byte |
| st_wr_acc | input | 5 | New accrued bits 7:3 |
| enable_q | output | 8 | Current trap-enable byte |
| status_q | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle trap request |
| trap_vec | output | 8 | Vector number, valid with `trap_req` |
| commit | output | 1 | One-cycle commit strobe |

## Verification
Two cases can fall in the same cycle:
- The end of an operation and a software write. This covers both a status write and an enable write.
- The start and end of an operation, which collide inside the status byte.

Directed steps drive a status write together with `op_done`, where the written exception byte alone must cause a trap. They also drive an enable write together with `op_done`, where the old enable byte must decide. Randomized steps then mix all of these at random rates. A bench model applies the write, then the clear, then the merge, and every register and strobe is compared against that model after each edge.

// File: rtl/fpx_trap_pkg.sv
package fpx_trap_pkg;
  localparam int EXC_W = 8;
  localparam int ACC_W = 5;
  localparam int ACC_LSB = 3;

  // per-operation byte positions (priority high to low)
  localparam int P_UNORD = 7;
  localparam int P_SNAN  = 6;
  localparam int P_OPERR = 5;
  localparam int P_OVFL  = 4;
  localparam int P_UNFL  = 3;
  localparam int P_DZ    = 2;
  localparam int P_INXR  = 1;
  localparam int P_INXD  = 0;

  typedef logic [EXC_W-1:0] exc_byte_t;
  typedef logic [ACC_W-1:0] acc_bits_t; // {invalid, ovfl, unfl, dz, inexact}

  function automatic acc_bits_t accrue_of(input exc_byte_t e);
    logic inval, ovf, unf, dz, inx;
    inval = e[P_UNORD] | e[P_SNAN] | e[P_OPERR];
    ovf   = e[P_OVFL];
    unf   = e[P_UNFL] & e[P_INXR];
    dz    = e[P_DZ];
    inx   = e[P_INXD] | e[P_INXR] | e[P_OVFL];
    return {inval, ovf, unf, dz, inx};
  endfunction

  // vector offset from the base for each status position
  function automatic logic [3:0] vec_offset(input int pos);
    case (pos)
      P_UNORD: return 4'd0;
      P_SNAN:  return 4'd6;
      P_OPERR: return 4'd4;
      P_OVFL:  return 4'd5;
      P_UNFL:  return 4'd3;
      P_DZ:    return 4'd2;
      default: return 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/fpx_status_regs.sv
module fpx_status_regs
  import fpx_trap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      op_start,
  input  logic      op_done,
  input  exc_byte_t evt_flags,
  input  logic      st_wr,
  input  exc_byte_t st_wr_exc,
  input  acc_bits_t st_wr_acc,
  output exc_byte_t exc_q,
  output acc_bits_t acc_q,
  output exc_byte_t exc_merged
);
  exc_byte_t exc_base;
  acc_bits_t acc_base;
  acc_bits_t acc_next;

  always_comb begin
    exc_base = st_wr ? st_wr_exc : exc_q;
    acc_base = st_wr ? st_wr_acc : acc_q;
    if (op_start) exc_base = '0;
    exc_merged = exc_base | (op_done ? evt_flags : '0);
    acc_next   = acc_base | (op_done ? accrue_of(exc_merged) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_q <= '0;
      acc_q <= '0;
    end else begin
      exc_q <= exc_merged;
      acc_q <= acc_next;
    end
  end
endmodule

// File: rtl/fpx_trap_prio.sv
module fpx_trap_prio
  import fpx_trap_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 48
) (
  input  exc_byte_t        exc,
  input  exc_byte_t        enable,
  output logic             hit,
  output logic [VEC_W-1:0] vec
);
  exc_byte_t pend;
  exc_byte_t sel;

  assign pend = exc & enable;
  assign hit  = |pend;

  for (genvar i = 0; i < EXC_W; i++) begin : g_sel
    if (i == EXC_W - 1) begin : g_top
      assign sel[i] = pend[i];
    end else begin : g_low
      assign sel[i] = pend[i] & ~(|pend[EXC_W-1:i+1]);
    end
  end

  always_comb begin
    vec = '0;
    for (int i = 0; i < EXC_W; i++) begin
      if (sel[i]) vec = vec | (VEC_W'(VEC_BASE) + VEC_W'(vec_offset(i)));
    end
  end
endmodule

// File: rtl/fpx_trap_out.sv
module fpx_trap_out #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_done,
  input  logic             hit,
  input  logic [VEC_W-1:0] vec_in,
  output logic             trap_req,
  output logic             commit,
  output logic [VEC_W-1:0] trap_vec
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req <= 1'b0;
      commit   <= 1'b0;
      trap_vec <= '0;
    end else begin
      trap_req <= op_done & hit;
      commit   <= op_done & ~hit;
      trap_vec <= (op_done & hit) ? vec_in : '0;
    end
  end
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
  import fpx_trap_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic             op_done,
  input  logic [7:0]       evt_flags,
  input  logic             en_wr,
  input  logic [7:0]       en_wr_data,
  input  logic             st_wr,
  input  logic [7:0]       st_wr_exc,
  input  logic [4:0]       st_wr_acc,
  output logic [7:0]       enable_q,
  output logic [31:0]      status_q,
  output logic             trap_req,
  output logic [VEC_W-1:0] trap_vec,
  output logic             commit
);
  localparam int HI_PAD = 32 - EXC_W - ACC_W - ACC_LSB;

  exc_byte_t        exc_q;
  acc_bits_t        acc_q;
  exc_byte_t        exc_merged;
  logic             trap_hit;
  logic [VEC_W-1:0] trap_vec_next;

  always_ff @(posedge clk) begin
    if (!rst_n) enable_q <= '0;
    else if (en_wr) enable_q <= en_wr_data;
  end

  fpx_status_regs u_regs (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done),
    .evt_flags(evt_flags), .st_wr(st_wr), .st_wr_exc(st_wr_exc),
    .st_wr_acc(st_wr_acc), .exc_q(exc_q), .acc_q(acc_q),
    .exc_merged(exc_merged)
  );

  fpx_trap_prio #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_prio (
    .exc(exc_merged), .enable(enable_q), .hit(trap_hit), .vec(trap_vec_next)
  );

  fpx_trap_out #(.VEC_W(VEC_W)) u_out (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .hit(trap_hit),
    .vec_in(trap_vec_next), .trap_req(trap_req), .commit(commit),
    .trap_vec(trap_vec)
  );

  assign status_q = {{HI_PAD{1'b0}}, exc_q, acc_q, {ACC_LSB{1'b0}}};
endmodule

// File: rtl/fpx_trap_chk.sv
module fpx_trap_chk #(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_start,
  input logic             op_done,
  input logic             st_wr,
  input logic [31:0]      status_q,
  input logic             trap_req,
  input logic             commit,
  input logic [VEC_W-1:0] trap_vec
);
  AST_TRAP_COMMIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req && commit)); // R9

  AST_DONE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> (trap_req || commit)); // R8

  AST_PULSE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req || commit) |-> $past(op_done)); // R9

  AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> (trap_vec == '0)); // R12

  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_vec >= VEC_W'(VEC_BASE) && trap_vec <= VEC_W'(VEC_BASE + 6))); // R8

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[31:16] == '0) && (status_q[2:0] == '0)); // R10

  AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> ((status_q[7:3] & $past(status_q[7:3])) == $past(status_q[7:3]))); // R7

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !op_done) |=> (status_q[15:8] == '0)); // R3
endmodule

bind fpx_trap_unit fpx_trap_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done),
  .st_wr(st_wr), .status_q(status_q), .trap_req(trap_req),
  .commit(commit), .trap_vec(trap_vec)
);

// File: tb/fpx_trap_unit_tb.sv
module fpx_trap_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, op_done = 0, en_wr = 0, st_wr = 0;
  logic [7:0] evt_flags = 0, en_wr_data = 0, st_wr_exc = 0;
  logic [4:0] st_wr_acc = 0;
  logic [7:0] enable_q, trap_vec;
  logic [31:0] status_q;
  logic trap_req, commit;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_en = 0, m_exc = 0;
  logic [4:0] m_acc = 0;

  always #2.5 clk = ~clk;

  fpx_trap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done),
    .evt_flags(evt_flags), .en_wr(en_wr), .en_wr_data(en_wr_data),
    .st_wr(st_wr), .st_wr_exc(st_wr_exc), .st_wr_acc(st_wr_acc),
    .enable_q(enable_q), .status_q(status_q), .trap_req(trap_req),
    .trap_vec(trap_vec), .commit(commit)
  );

  function automatic logic [4:0] b_accrue(input logic [7:0] e);
    logic [4:0] r;
    r[0] = (e & 8'h13) != 0;           // inexact: ovfl, inx result, inx decimal
    r[1] = e[2];                       // divide by zero
    r[2] = (e & 8'h0A) == 8'h0A;       // underflow needs inexact result too
    r[3] = e[4];                       // overflow
    r[4] = (e & 8'hE0) != 0;           // invalid
    return r;
  endfunction

  function automatic logic [7:0] b_vec(input logic [7:0] p);
    int vt[8] = '{49, 49, 50, 51, 53, 52, 54, 48};
    for (int i = 7; i >= 0; i--) if (p[i]) return 8'(vt[i]);
    return 8'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic d, input logic [7:0] ev,
                      input logic ew, input logic [7:0] ed,
                      input logic sw, input logic [7:0] se, input logic [4:0] sa,
                      input string tag);
    logic [7:0] b_exc, p, e_vec;
    logic [4:0] b_acc;
    logic e_trap, e_com;
    op_start = s; op_done = d; evt_flags = ev;
    en_wr = ew; en_wr_data = ed; st_wr = sw; st_wr_exc = se; st_wr_acc = sa;
    b_exc = sw ? se : m_exc;
    b_acc = sw ? sa : m_acc;
    if (s) b_exc = 8'h00;
    if (d) begin
      b_exc = b_exc | ev;
      b_acc = b_acc | b_accrue(b_exc);
    end
    p = b_exc & m_en;
    e_trap = d && (p != 0);
    e_com  = d && (p == 0);
    e_vec  = e_trap ? b_vec(p) : 8'd0;
    m_exc = b_exc; m_acc = b_acc;
    if (ew) m_en = ed;
    @(posedge clk); #1;
    chk(status_q == {16'h0, m_exc, m_acc, 3'b000}, tag, "status", status_q,
        {16'h0, m_exc, m_acc, 3'b000});
    chk(enable_q == m_en, tag, "enable", {24'h0, enable_q}, {24'h0, m_en});
    chk(trap_req == e_trap, tag, "trap_req", {31'h0, trap_req}, {31'h0, e_trap});
    chk(commit == e_com, tag, "commit", {31'h0, commit}, {31'h0, e_com});
    chk(trap_vec == e_vec, tag, "trap_vec", {24'h0, trap_vec}, {24'h0, e_vec});
    op_start = 0; op_done = 0; en_wr = 0; st_wr = 0; evt_flags = 0;
  endtask

  task automatic op(input logic [7:0] ev, input string tag);
    step(1, 1, ev, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(status_q == 0, "R1", "status", status_q, 0);
    chk(enable_q == 0, "R1", "enable", {24'h0, enable_q}, 0);
    chk(!trap_req && !commit && trap_vec == 0, "R1", "strobes",
        {22'h0, trap_req, commit, trap_vec}, 0);
    rst_n = 1;

    // R9: no enables, events still commit
    op(8'h04, "R9");
    // R6: underflow without inexact result does not accrue underflow
    op(8'h08, "R6");
    chk(status_q[5] == 1'b0, "R6", "acc unfl alone", {31'h0, status_q[5]}, 0);
    op(8'h0A, "R6");
    chk(status_q[5] == 1'b1, "R6", "acc unfl+inx", {31'h0, status_q[5]}, 1);
    // R5 invalid sources
    op(8'h40, "R5");
    chk(status_q[7] == 1'b1, "R5", "acc invalid", {31'h0, status_q[7]}, 1);
    // R10: clear by write, padding zero
    step(0, 0, 0, 0, 0, 1, 8'hFF, 5'h1F, "R10");
    chk(status_q == 32'h0000_FFF8, "R10", "full write", status_q, 32'h0000_FFF8);
    step(0, 0, 0, 0, 0, 1, 8'h00, 5'h00, "R10");
    // R7 overflow feeds overflow and inexact
    op(8'h10, "R7");
    chk(status_q[7:3] == 5'b01001, "R7", "ovfl accrual", {27'h0, status_q[7:3]}, 5'b01001);
    op(8'h01, "R7");
    // R3: start alone clears byte, keeps accrued
    op(8'h24, "R3");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    chk(status_q[15:8] == 0 && status_q[7:3] != 0, "R3", "start only",
        status_q, {16'h0, 8'h00, m_acc, 3'b0});
    // R4: op_done without start accumulates into byte
    step(0, 1, 8'h01, 0, 0, 0, 0, 0, "R4");
    step(0, 1, 8'h04, 0, 0, 0, 0, 0, "R4");
    // R2: enable all
    step(0, 0, 0, 1, 8'hFF, 0, 0, 0, "R2");
    // R8: each single bit gives its vector
    for (int i = 0; i < 8; i++) op(8'(1 << i), "R8");
    op(8'h30, "R8");   // operr over ovfl: 52
    op(8'h18, "R8");   // ovfl over unfl: 53
    op(8'h03, "R8");   // both inexact: 49
    step(0, 0, 0, 1, 8'h04, 0, 0, 0, "R8");
    op(8'hFB, "R8");   // nothing enabled hits: commit
    op(8'hFF, "R8");   // only dz: 50
    // R11: enable write with done uses old enable
    step(0, 0, 0, 1, 8'h00, 0, 0, 0, "R11");
    step(1, 1, 8'h04, 1, 8'hFF, 0, 0, 0, "R11");
    // R11: status write with done is the base
    step(0, 0, 0, 1, 8'h80, 0, 0, 0, "R11");
    step(0, 1, 8'h00, 0, 0, 1, 8'h80, 5'h00, "R11");
    step(1, 1, 8'h00, 0, 0, 1, 8'h80, 5'h00, "R11");
    // R12 covered by every non-trap step; random mix
    for (int k = 0; k < 400; k++) begin
      logic [7:0] ev;
      ev = 8'($urandom) & 8'($urandom);
      step(($urandom % 2) == 0, ($urandom % 2) == 0, ev,
           ($urandom % 8) == 0, 8'($urandom),
           ($urandom % 16) == 0, 8'($urandom), 5'($urandom), "R12");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule